// File: doc/BRIEF.md
# Capture Readout and Width Adapter

This block drains a completed capture from a circular sample buffer and delivers it on an output data path whose width differs from the sample width. When the capture side reports that storage is complete, it pulses `go` together with the buffer address of the oldest sample to be delivered. The block then issues a fixed-length run of sequential read addresses to the external buffer RAM. The addresses wrap to zero past the last buffer entry.

The RAM answers each read some cycles later with data and a valid flag. The block takes in data only while that flag is high and keeps the RAM's return order. Each returned sample then goes through a width adapter set at elaboration. In split mode each wide sample is cut into several narrower bus words, one per cycle. In pack mode several narrow samples are merged into one wider bus word. The ratio is always a power of two.

A small internal queue sits between the RAM return path and the adapter. The address sequencer issues a read only while the queue has a free slot reserved for it, so the RAM latency can be any length and a multi-cycle split never loses a sample. After the final bus word has gone out, a one-cycle completion pulse tells the surrounding system that a new capture can be armed.

Top module: `capture_drain`

## Requirements
- R1: After a synchronous active-high reset, `rd_en`, `out_valid` and `done` are all 0.
- R2: A `go` pulse while idle starts a run: the first read address is `start_addr`, and each following address is the previous one plus one.
- R3: The read address that follows `DEPTH-1` is 0, so a run may start anywhere in the buffer.
- R4: Every run issues exactly `REC_LEN` read strobes, and none is issued in the cycle `done` is high.
- R5: `rd_data` is accepted only in cycles where `rd_valid` is 1. Whatever is on `rd_data` while `rd_valid` is 0 has no effect on the output. Samples leave in the order the RAM returned them.
- R6: Split mode (`PACK`=0, `SAMPLE_W` = `BUS_W`·2^`RATIO_LOG2`): each sample becomes 2^`RATIO_LOG2` consecutive bus words. The first word carries bits [`BUS_W`-1:0], and each later word carries the next higher slice.
- R7: Pack mode (`PACK`=1, `BUS_W` = `SAMPLE_W`·2^`RATIO_LOG2`): consecutive samples fill lanes from the bottom. The earliest sample sits in bits [`SAMPLE_W`-1:0]. If the run ends before a word is full, that last word is sent with its unfilled upper lanes at 0.
- R8: `out_last` is 1 together with `out_valid` on the final word of a run and is 0 on every other word.
- R9: `done` is high for exactly one cycle, the cycle right after the word that carried `out_last`.
- R10: A `go` pulse that arrives while a run is in progress is ignored. The run's addresses and data are unchanged.
- R11: No sample is dropped, whatever the RAM latency: the number of reads waiting for a queue slot never exceeds the queue depth, and a run yields REC_LEN·2^RATIO_LOG2 words in split mode or ceil(REC_LEN/2^RATIO_LOG2) words in pack mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start pulse from the capture side |
| start_addr | input | $clog2(DEPTH) | Buffer address of the first sample to read |
| rd_en | output | 1 | Read strobe to the buffer RAM |
| rd_addr | output | $clog2(DEPTH) | Read address to the buffer RAM |
| rd_data | input | SAMPLE_W | Returned sample from the buffer RAM |
| rd_valid | input | 1 | Marks a cycle in which rd_data holds a returned sample |
| out_valid | output | 1 | Output word strobe |
| out_data | output | BUS_W | Output word |
| out_last | output | 1 | Marks the final word of a run |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The checks that run on every cycle guard the internal queue against overflow and underflow and keep the reservation count within the queue depth. They also keep read addresses inside the buffer and enforce the single-cycle `done` pulse that follows `out_last` with no read strobe beside it. Some behaviour can only be shown by the bench scenarios, because it depends on comparing a whole run with the buffer contents. This covers the exact address sequence and its wrap, the lane order of split and packed words, the zero fill of a short final packed word, the rejection of junk data between valid returns, and the rejection of a second start during a run. The bench drives two instances, one in each adapter direction, and gives their RAM models different latencies.

// File: rtl/cd_pkg.sv
package cd_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // Output bus width from the sample width, the ratio exponent and the direction
  function automatic int bus_width(input int sample_w, input int ratio_log2, input bit pack);
    return pack ? (sample_w << ratio_log2) : (sample_w >> ratio_log2);
  endfunction

endpackage

// File: rtl/cd_addr_seq.sv
module cd_addr_seq
  import cd_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int REC_LEN = 8,
  parameter int CREDITS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(REC_LEN + 1),
  localparam int CW = $clog2(CREDITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic          credit_ret,
  input  logic          run_end,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);

  seq_state_t    state;
  logic [AW-1:0] nxt_addr;
  logic [LW-1:0] issued;
  logic [CW-1:0] credit;
  logic          issue;

  // A read goes out only while a queue slot is reserved for its return
  assign issue = (state == SEQ_RUN) && (credit != '0) && (issued != LW'(REC_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      nxt_addr <= '0;
      issued   <= '0;
      credit   <= CW'(CREDITS);
      rd_en    <= 1'b0;
      rd_addr  <= '0;
    end else begin
      rd_en  <= issue;
      credit <= credit + CW'(credit_ret) - CW'(issue);
      if (issue) begin
        rd_addr  <= nxt_addr;
        nxt_addr <= (nxt_addr == AW'(DEPTH - 1)) ? '0 : nxt_addr + 1'b1;
        issued   <= issued + 1'b1;
      end
      if (state == SEQ_IDLE && go) begin
        state    <= SEQ_RUN;
        nxt_addr <= start_addr;
        issued   <= '0;
      end else if (state == SEQ_RUN && run_end) begin
        state <= SEQ_IDLE;
      end
    end
  end

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst) credit <= CW'(CREDITS)); // R11
  AST_ADDR_IN_BUFFER: assert property (@(posedge clk) disable iff (rst) rd_en |-> (rd_addr <= AW'(DEPTH - 1))); // R3

endmodule

// File: rtl/cd_sample_fifo.sv
module cd_sample_fifo #(
  parameter int W     = 17,
  parameter int LOG2D = 2,
  localparam int D    = 1 << LOG2D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);

  logic [W-1:0]   mem [D];
  logic [LOG2D:0] wp, rp;
  logic           full;

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp[LOG2D-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign dout  = mem[rp[LOG2D-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[LOG2D] != rp[LOG2D]) && (wp[LOG2D-1:0] == rp[LOG2D-1:0]);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R5

endmodule

// File: rtl/cd_width_adapt.sv
module cd_width_adapt #(
  parameter int SAMPLE_W   = 16,
  parameter int RATIO_LOG2 = 1,
  parameter bit PACK       = 1'b0,
  localparam int BUS_W = cd_pkg::bus_width(SAMPLE_W, RATIO_LOG2, PACK),
  localparam int N     = 1 << RATIO_LOG2,
  localparam int IW    = (RATIO_LOG2 > 0) ? RATIO_LOG2 : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_avail,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_last,
  output logic                take,
  output logic                out_valid,
  output logic [BUS_W-1:0]    out_data,
  output logic                out_last
);

  if (PACK == 1'b0) begin : g_split
    logic [SAMPLE_W-1:0] sh;
    logic [IW-1:0]       idx;
    logic                holding;
    logic                hold_last;
    logic                final_part;

    assign final_part = (idx == IW'(N - 1));
    // A new sample loads in the cycle its predecessor's last slice leaves
    assign take = in_avail && (!holding || final_part);

    always_ff @(posedge clk) begin
      if (rst) begin
        sh        <= '0;
        idx       <= '0;
        holding   <= 1'b0;
        hold_last <= 1'b0;
        out_valid <= 1'b0;
        out_data  <= '0;
        out_last  <= 1'b0;
      end else begin
        out_valid <= holding;
        out_last  <= holding && hold_last && final_part;
        if (holding) begin
          out_data <= sh[BUS_W-1:0];
          sh       <= sh >> BUS_W;
          idx      <= final_part ? '0 : idx + 1'b1;
        end
        if (take) begin
          sh        <= in_data;
          hold_last <= in_last;
          idx       <= '0;
          holding   <= 1'b1;
        end else if (holding && final_part) begin
          holding <= 1'b0;
        end
      end
    end
  end else begin : g_pack
    logic [BUS_W-1:0] acc;
    logic [BUS_W-1:0] merged;
    logic [IW-1:0]    lane;

    assign take = in_avail;

    always_comb begin
      merged = acc | (BUS_W'(in_data) << (lane * SAMPLE_W));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc       <= '0;
        lane      <= '0;
        out_valid <= 1'b0;
        out_data  <= '0;
        out_last  <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
        if (take) begin
          if (lane == IW'(N - 1) || in_last) begin
            out_valid <= 1'b1;
            out_data  <= merged;
            out_last  <= in_last;
            acc       <= '0;
            lane      <= '0;
          end else begin
            acc  <= merged;
            lane <= lane + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/capture_drain.sv
module capture_drain #(
  parameter int SAMPLE_W   = 16,
  parameter int RATIO_LOG2 = 1,
  parameter bit PACK       = 1'b0,
  parameter int DEPTH      = 32,
  parameter int REC_LEN    = 8,
  parameter int FIFO_LOG2  = 2,
  localparam int BUS_W = cd_pkg::bus_width(SAMPLE_W, RATIO_LOG2, PACK),
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(REC_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [AW-1:0]       start_addr,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  input  logic [SAMPLE_W-1:0] rd_data,
  input  logic                rd_valid,
  output logic                out_valid,
  output logic [BUS_W-1:0]    out_data,
  output logic                out_last,
  output logic                done
);

  logic [LW-1:0]     ret_cnt;
  logic              tag_last;
  logic [SAMPLE_W:0] q_dout;
  logic              q_empty;
  logic              take_w;

  // Count returned samples so the final one carries the end tag
  always_ff @(posedge clk) begin
    if (rst)           ret_cnt <= '0;
    else if (done)     ret_cnt <= '0;
    else if (rd_valid) ret_cnt <= ret_cnt + 1'b1;
  end
  assign tag_last = (ret_cnt == LW'(REC_LEN - 1));

  cd_addr_seq #(
    .DEPTH  (DEPTH),
    .REC_LEN(REC_LEN),
    .CREDITS(1 << FIFO_LOG2)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .start_addr(start_addr),
    .credit_ret(take_w),
    .run_end   (done),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
  );

  cd_sample_fifo #(
    .W    (SAMPLE_W + 1),
    .LOG2D(FIFO_LOG2)
  ) u_queue (
    .clk  (clk),
    .rst  (rst),
    .push (rd_valid),
    .din  ({tag_last, rd_data}),
    .pop  (take_w),
    .dout (q_dout),
    .empty(q_empty)
  );

  cd_width_adapt #(
    .SAMPLE_W  (SAMPLE_W),
    .RATIO_LOG2(RATIO_LOG2),
    .PACK      (PACK)
  ) u_adapt (
    .clk      (clk),
    .rst      (rst),
    .in_avail (!q_empty),
    .in_data  (q_dout[SAMPLE_W-1:0]),
    .in_last  (q_dout[SAMPLE_W]),
    .take     (take_w),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= out_valid && out_last;
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) (out_valid && out_last) |=> done); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !rd_en); // R4

endmodule

// File: tb/tb_capture_drain.sv
module tb_capture_drain;

  localparam int SW = 16, SR = 1, SD = 32, SL = 8, SAW = 5, SBW = 8;
  localparam int PW = 8,  PR = 1, PD = 16, PL = 7, PAW = 4, PBW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int vectors = 0;
  int fails   = 0;

  // split instance signals
  logic           s_go = 1'b0;
  logic [SAW-1:0] s_start = '0;
  logic           s_rd_en;
  logic [SAW-1:0] s_rd_addr;
  logic [SW-1:0]  s_rd_data;
  logic           s_rd_valid;
  logic           s_ov, s_ol, s_done;
  logic [SBW-1:0] s_od;

  // pack instance signals
  logic           p_go = 1'b0;
  logic [PAW-1:0] p_start = '0;
  logic           p_rd_en;
  logic [PAW-1:0] p_rd_addr;
  logic [PW-1:0]  p_rd_data;
  logic           p_rd_valid;
  logic           p_ov, p_ol, p_done;
  logic [PBW-1:0] p_od;

  capture_drain #(.SAMPLE_W(SW), .RATIO_LOG2(SR), .PACK(1'b0), .DEPTH(SD), .REC_LEN(SL), .FIFO_LOG2(2)) dut (
    .clk(clk), .rst(rst), .go(s_go), .start_addr(s_start),
    .rd_en(s_rd_en), .rd_addr(s_rd_addr), .rd_data(s_rd_data), .rd_valid(s_rd_valid),
    .out_valid(s_ov), .out_data(s_od), .out_last(s_ol), .done(s_done));

  capture_drain #(.SAMPLE_W(PW), .RATIO_LOG2(PR), .PACK(1'b1), .DEPTH(PD), .REC_LEN(PL), .FIFO_LOG2(2)) dut_pack (
    .clk(clk), .rst(rst), .go(p_go), .start_addr(p_start),
    .rd_en(p_rd_en), .rd_addr(p_rd_addr), .rd_data(p_rd_data), .rd_valid(p_rd_valid),
    .out_valid(p_ov), .out_data(p_od), .out_last(p_ol), .done(p_done));

  // RAM models: split side has 3-cycle latency, pack side 1-cycle; junk when not valid
  logic [SW-1:0]  memS [SD];
  logic [PW-1:0]  memP [PD];
  logic [2:0]     s_vp;
  logic [SAW-1:0] s_ap0, s_ap1, s_ap2;
  logic [SW-1:0]  s_junk;
  logic           p_vp;
  logic [PAW-1:0] p_ap;
  logic [PW-1:0]  p_junk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vp <= '0;
      p_vp <= 1'b0;
    end else begin
      s_vp <= {s_vp[1:0], s_rd_en};
      p_vp <= p_rd_en;
    end
    s_ap0  <= s_rd_addr;
    s_ap1  <= s_ap0;
    s_ap2  <= s_ap1;
    p_ap   <= p_rd_addr;
    s_junk <= SW'($urandom);
    p_junk <= PW'($urandom);
  end

  assign s_rd_valid = s_vp[2];
  assign s_rd_data  = s_vp[2] ? memS[s_ap2] : s_junk;
  assign p_rd_valid = p_vp;
  assign p_rd_data  = p_vp ? memP[p_ap] : p_junk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitors
  logic [SAW-1:0] s_addrs [$];
  logic [SBW-1:0] s_words [$];
  bit             s_lasts [$];
  bit             s_exp_done = 1'b0, s_fin = 1'b0;
  logic [PAW-1:0] p_addrs [$];
  logic [PBW-1:0] p_words [$];
  bit             p_lasts [$];
  bit             p_exp_done = 1'b0, p_fin = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (s_rd_en) s_addrs.push_back(s_rd_addr);
      if (s_ov) begin s_words.push_back(s_od); s_lasts.push_back(s_ol); end
      if (s_done || s_exp_done) check(s_done === s_exp_done, "R9 split done", s_done, s_exp_done);
      s_exp_done = s_ov && s_ol;
      if (s_done) s_fin = 1'b1;
      if (p_rd_en) p_addrs.push_back(p_rd_addr);
      if (p_ov) begin p_words.push_back(p_od); p_lasts.push_back(p_ol); end
      if (p_done || p_exp_done) check(p_done === p_exp_done, "R9 pack done", p_done, p_exp_done);
      p_exp_done = p_ov && p_ol;
      if (p_done) p_fin = 1'b1;
    end
  end

  function automatic logic [SBW-1:0] exp_split(input int st, input int j);
    logic [SW-1:0] smp = memS[(st + j / 2) % SD];
    return (j % 2 == 1) ? smp[15:8] : smp[7:0];
  endfunction

  function automatic logic [PBW-1:0] exp_pack(input int st, input int k);
    logic [PW-1:0] lo = memP[(st + 2 * k) % PD];
    logic [PW-1:0] hi = (2 * k + 1 < PL) ? memP[(st + 2 * k + 1) % PD] : '0;
    return {hi, lo};
  endfunction

  task automatic run_split(input int st, input bit poke);
    string atag;
    for (int i = 0; i < SD; i++) memS[i] = SW'($urandom);
    s_addrs.delete(); s_words.delete(); s_lasts.delete(); s_fin = 1'b0;
    @(negedge clk); s_start = SAW'(st); s_go = 1'b1;
    @(negedge clk); s_go = 1'b0;
    if (poke) begin  // R10: second start mid-run
      repeat (3) @(negedge clk);
      s_start = SAW'(st ^ 7); s_go = 1'b1;
      @(negedge clk); s_go = 1'b0;
    end
    for (int c = 0; c < 400 && !s_fin; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(s_fin, "R9 split done seen", s_fin, 1);
    check(s_addrs.size() == SL, "R4 split read count", s_addrs.size(), SL);
    for (int i = 0; i < s_addrs.size() && i < SL; i++) begin
      atag = poke ? "R10 split addr" : ((st + i >= SD) ? "R3 split wrap addr" : "R2 split addr");
      check(int'(s_addrs[i]) == (st + i) % SD, atag, s_addrs[i], (st + i) % SD);
    end
    check(s_words.size() == SL * 2, "R11 split word count", s_words.size(), SL * 2);
    for (int j = 0; j < s_words.size() && j < SL * 2; j++) begin
      check(s_words[j] == exp_split(st, j), "R6 R5 split word", s_words[j], exp_split(st, j));
      check(s_lasts[j] == (j == SL * 2 - 1), "R8 split last", s_lasts[j], (j == SL * 2 - 1));
    end
  endtask

  task automatic run_pack(input int st, input bit poke);
    string atag;
    int nw = (PL + 1) / 2;
    for (int i = 0; i < PD; i++) memP[i] = PW'($urandom);
    p_addrs.delete(); p_words.delete(); p_lasts.delete(); p_fin = 1'b0;
    @(negedge clk); p_start = PAW'(st); p_go = 1'b1;
    @(negedge clk); p_go = 1'b0;
    if (poke) begin  // R10: second start mid-run
      repeat (2) @(negedge clk);
      p_start = PAW'(st ^ 5); p_go = 1'b1;
      @(negedge clk); p_go = 1'b0;
    end
    for (int c = 0; c < 400 && !p_fin; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(p_fin, "R9 pack done seen", p_fin, 1);
    check(p_addrs.size() == PL, "R4 pack read count", p_addrs.size(), PL);
    for (int i = 0; i < p_addrs.size() && i < PL; i++) begin
      atag = poke ? "R10 pack addr" : ((st + i >= PD) ? "R3 pack wrap addr" : "R2 pack addr");
      check(int'(p_addrs[i]) == (st + i) % PD, atag, p_addrs[i], (st + i) % PD);
    end
    check(p_words.size() == nw, "R11 pack word count", p_words.size(), nw);
    for (int k = 0; k < p_words.size() && k < nw; k++) begin
      check(p_words[k] == exp_pack(st, k), "R7 R5 pack word", p_words[k], exp_pack(st, k));
      check(p_lasts[k] == (k == nw - 1), "R8 pack last", p_lasts[k], (k == nw - 1));
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check(!s_rd_en && !s_ov && !s_done, "R1 split reset", {s_rd_en, s_ov, s_done}, 0);
    check(!p_rd_en && !p_ov && !p_done, "R1 pack reset", {p_rd_en, p_ov, p_done}, 0);

    run_split(0, 1'b0);
    run_split(SD - 1, 1'b0);   // wrap right away
    run_split(SD - 3, 1'b1);   // wrap plus ignored start
    for (int n = 0; n < 5; n++) run_split(int'($urandom % SD), 1'b0);

    run_pack(PD - 1, 1'b0);    // wrap, odd length leaves half word
    run_pack(4, 1'b1);
    for (int n = 0; n < 5; n++) run_pack(int'($urandom % PD), 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule